// File: doc/BRIEF.md
# Two-Client Handshake Arbiter

This block shares one resource between two clients that each talk to it through a four-phase request/grant handshake. A client raises its request, waits for its grant, uses the resource, then lowers its request and waits for the grant to fall before it may ask again. Both request lines are brought into the clock domain through a chain of flip-flops, and a small state machine decides who owns the resource.

The state register takes four codes: idle `00`, client 1 owns `01`, transfer `11` and client 2 owns `10`. The codes are arranged so that every move changes exactly one state bit. The two owning codes are never adjacent, so a direct switch from one owner to the other is impossible. Instead, a handover passes through the transfer code, and no grant is driven while the block sits there. A grant is shown only while the machine is in the owning state and that client's synchronised request is still high. As a result, a grant falls as soon as its request is seen low, and no grant is ever issued to a client that has already withdrawn.

Top module: `duo_grant_arbiter`

## Requirements
- R1: While `rst` is high, and on the first rising edge at which it is sampled high, both grants go low and the arbiter returns to idle. The grants stay low after reset until a request arrives.
- R2: `gnt1` and `gnt2` are never high together.
- R3: From idle, a lone request causes its grant to rise on the third rising edge after the request is driven: two synchroniser stages plus one state update.
- R4: When both requests are seen together in idle, client 1 receives the grant and client 2 does not.
- R5: A client that holds the grant keeps it for as long as its own request stays high, even while the other client is requesting.
- R6: A grant falls on the second rising edge after its own request is lowered. If the other client is not requesting, the arbiter returns to idle.
- R7: If the owner lowers its request while the other client is requesting, the arbiter passes through the transfer code `11` for one cycle with both grants low. The waiting client's grant then rises on the fourth rising edge after the owner's request fell. Every state move changes exactly one bit of the code, with idle `00`, client 1 `01` and client 2 `10`.
- R8: If the handover's destination client lowers its request before its grant appears, no grant is issued to it and the arbiter settles in idle.
- R9: A client that is requesting is granted within 6 cycles of waiting while the other client's request is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req1 | input | 1 | Client 1 request (asynchronous) |
| req2 | input | 1 | Client 2 request (asynchronous) |
| gnt1 | output | 1 | Client 1 grant |
| gnt2 | output | 1 | Client 2 grant |

## Verification
The hardest situation to reach from the ports is an aborted handover. The owner releases while the other client is waiting, and the waiting client then withdraws during the two-cycle synchroniser gap. The arbiter is then committed to a destination whose request has already gone. The directed sequence creates this by lowering the two requests on consecutive cycles, and then confirms that both grants stay low until the arbiter is idle. A long run of random handshaking clients with random hold times then covers the remaining orderings, checking exclusion and the bound on waiting.

// File: rtl/duo_arb_pkg.sv
package duo_arb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_OWN1  = 2'b01,
    ST_XFER  = 2'b11,
    ST_OWN2  = 2'b10
  } arb_state_t;

  // Number of differing bits between two state codes.
  function automatic int unsigned code_distance(input logic [1:0] a, input logic [1:0] b);
    return $countones(a ^ b);
  endfunction

endpackage

// File: rtl/duo_arb_sync.sv
module duo_arb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/duo_arb_fsm.sv
module duo_arb_fsm
  import duo_arb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic want1,
  input  logic want2,
  output logic grant1,
  output logic grant2
);
  arb_state_t st_q, st_d;
  logic       dest2_q, dest2_d;   // handover destination: 1 = client 2

  // named events for the assertions
  logic leave1, leave2, in_idle;

  assign in_idle = (st_q == ST_IDLE);
  assign leave1  = (st_q == ST_OWN1) && !want1;
  assign leave2  = (st_q == ST_OWN2) && !want2;

  always_comb begin
    st_d    = st_q;
    dest2_d = dest2_q;
    unique case (st_q)
      ST_IDLE: begin
        if (want1)      st_d = ST_OWN1;
        else if (want2) st_d = ST_OWN2;
      end
      ST_OWN1: begin
        if (leave1) begin
          if (want2) begin st_d = ST_XFER; dest2_d = 1'b1; end
          else          st_d = ST_IDLE;
        end
      end
      ST_OWN2: begin
        if (leave2) begin
          if (want1) begin st_d = ST_XFER; dest2_d = 1'b0; end
          else          st_d = ST_IDLE;
        end
      end
      ST_XFER: st_d = dest2_q ? ST_OWN2 : ST_OWN1;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      dest2_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      dest2_q <= dest2_d;
    end
  end

  assign grant1 = (st_q == ST_OWN1) && want1;
  assign grant2 = (st_q == ST_OWN2) && want2;

  p_mutex_r2: assert property (@(posedge clk) disable iff (rst)
    !(grant1 && grant2));

  p_keep1_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(grant1) |-> !want1);

  p_keep2_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(grant2) |-> !want2);

  p_prio_r4: assert property (@(posedge clk) disable iff (rst)
    (in_idle && want1 && want2) |=> (st_q == ST_OWN1));

  p_onebit_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q != $past(st_q)) |-> (code_distance(st_q, $past(st_q)) == 1));

  p_xfer12_r7: assert property (@(posedge clk) disable iff (rst)
    (leave1 && want2) |=> (st_q == ST_XFER) ##1 (st_q == ST_OWN2));

  p_xfer21_r7: assert property (@(posedge clk) disable iff (rst)
    (leave2 && want1) |=> (st_q == ST_XFER) ##1 (st_q == ST_OWN1));
endmodule

// File: rtl/duo_grant_arbiter.sv
module duo_grant_arbiter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req1,
  input  logic req2,
  output logic gnt1,
  output logic gnt2
);
  localparam int CLIENTS = 2;

  logic [CLIENTS-1:0] req_raw, req_sync;

  assign req_raw = {req2, req1};

  for (genvar i = 0; i < CLIENTS; i++) begin : g_sync
    duo_arb_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (req_raw[i]),
      .q   (req_sync[i])
    );
  end

  duo_arb_fsm u_fsm (
    .clk    (clk),
    .rst    (rst),
    .want1  (req_sync[0]),
    .want2  (req_sync[1]),
    .grant1 (gnt1),
    .grant2 (gnt2)
  );
endmodule

// File: tb/duo_grant_arbiter_tb.sv
module duo_grant_arbiter_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req1 = 1'b0, req2 = 1'b0;
  logic gnt1, gnt2;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  duo_grant_arbiter u_dut (
    .clk(clk), .rst(rst), .req1(req1), .req2(req2), .gnt1(gnt1), .gnt2(gnt2)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: gnt2gnt1 actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual expired expected finished");
      summary();
    end
  end

  initial begin
    logic [1:0] r, g;
    int         hold[2];
    int         waitc[2];
    // R1 reset
    tick(3);
    chk("R1 in reset", {gnt2, gnt1}, 2'b00);
    rst = 1'b0;
    tick(4);
    chk("R1 after reset", {gnt2, gnt1}, 2'b00);

    // R3 lone request from idle
    req1 = 1'b1;
    tick(2); chk("R3 not yet", {gnt2, gnt1}, 2'b00);
    tick(1); chk("R3 grant 1", {gnt2, gnt1}, 2'b01);

    // R5 hold while other requests
    req2 = 1'b1;
    tick(5); chk("R5 hold 1", {gnt2, gnt1}, 2'b01);

    // R6/R7 handover 1 -> 2
    req1 = 1'b0;
    tick(1); chk("R6 still held", {gnt2, gnt1}, 2'b01);
    tick(1); chk("R6 grant falls", {gnt2, gnt1}, 2'b00);
    tick(1); chk("R7 transfer gap", {gnt2, gnt1}, 2'b00);
    tick(1); chk("R7 grant 2", {gnt2, gnt1}, 2'b10);

    // R6 release to idle
    req2 = 1'b0;
    tick(2); chk("R6 release 2", {gnt2, gnt1}, 2'b00);
    tick(3);

    // R4 simultaneous from idle
    req1 = 1'b1; req2 = 1'b1;
    tick(3); chk("R4 client 1 wins", {gnt2, gnt1}, 2'b01);
    tick(3); chk("R4 still client 1", {gnt2, gnt1}, 2'b01);

    // R7 handover 1 -> 2, then 2 -> 1
    req1 = 1'b0;
    tick(4); chk("R7 grant 2 after release", {gnt2, gnt1}, 2'b10);
    req1 = 1'b1;
    tick(4); chk("R5 hold 2", {gnt2, gnt1}, 2'b10);
    req2 = 1'b0;
    tick(2); chk("R7 reverse gap a", {gnt2, gnt1}, 2'b00);
    tick(1); chk("R7 reverse gap b", {gnt2, gnt1}, 2'b00);
    tick(1); chk("R7 grant 1 again", {gnt2, gnt1}, 2'b01);

    // R3 lone request of client 2
    req1 = 1'b0;
    tick(5); chk("R6 idle again", {gnt2, gnt1}, 2'b00);
    req2 = 1'b1;
    tick(2); chk("R3 not yet 2", {gnt2, gnt1}, 2'b00);
    tick(1); chk("R3 grant 2", {gnt2, gnt1}, 2'b10);

    // R8 aborted handover: holder drops, waiter drops one cycle later
    req1 = 1'b1;
    tick(3); chk("R5 hold 2 with waiter", {gnt2, gnt1}, 2'b10);
    req2 = 1'b0;
    tick(1);
    req1 = 1'b0;
    for (int k = 0; k < 6; k++) begin
      tick(1); chk("R8 no grant after abort", {gnt2, gnt1}, 2'b00);
    end
    req2 = 1'b1;
    tick(3); chk("R8 idle reached, grant 2", {gnt2, gnt1}, 2'b10);

    // R1 reset while a grant is held
    rst = 1'b1;
    tick(1); chk("R1 reset clears grant", {gnt2, gnt1}, 2'b00);
    req2 = 1'b0;
    tick(2);
    rst = 1'b0;
    tick(3);

    // R2/R9 random four-phase clients
    r = 2'b00;
    hold[0] = 0; hold[1] = 0; waitc[0] = 0; waitc[1] = 0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      g = {gnt2, gnt1};
      chk("R2 exclusion", {1'b0, g[0] & g[1]}, 2'b00);
      for (int i = 0; i < 2; i++) begin
        if (r[i] && !g[i] && !r[1-i]) waitc[i]++;
        if (g[i] || !r[i]) waitc[i] = 0;
        if (waitc[i] > 6) begin
          chk("R9 waiting bound", 2'b11, 2'b00);
          waitc[i] = 0;
        end
      end
      for (int i = 0; i < 2; i++) begin
        if (!r[i] && !g[i]) begin
          if ($urandom_range(3) == 0) begin
            r[i] = 1'b1;
            hold[i] = $urandom_range(9);
          end
        end else if (r[i] && g[i]) begin
          if (hold[i] == 0) r[i] = 1'b0;
          else hold[i]--;
        end
      end
      req1 = r[0]; req2 = r[1];
      tick(1);
    end

    done = 1'b1;
    summary();
  end
endmodule